// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the finite-state controller of a 32-bit multicycle load/store processor. Instruction and data share one memory. Each instruction spends one cycle in fetch and one in decode. It then takes a short path chosen by its opcode, and each cycle of that path drives the select and enable lines of the datapath. The controller covers loads, stores, register-register arithmetic, branch-if-equal, jump and load-upper-immediate. Load-upper-immediate uses the ALU to shift the immediate left by 16 bits.

Two conditions send the controller to one trap cycle: an undefined opcode seen in decode, or an arithmetic overflow flagged during the completion cycle of a register-register instruction. In the trap cycle it writes a one-bit reason code and the faulting instruction's address into their registers. The address is PC-4, formed by the ALU. In the same cycle it redirects the PC to a fixed handler address, then fetches again.

All ports are plain level signals with no handshake. The datapath follows the control lines in the same cycle, so no back-pressure exists.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_n is low, every output is 0. After release, the first cycle is a fetch cycle.
- R2: A fetch cycle drives mem_rd_o=1, ir_wr_o=1, pc_wr_o=1, alu_b_sel_o=01 (constant 4), alu_op_o=00 (add) and pc_src_o=00 (ALU result). It is always followed by a decode cycle.
- R3: A decode cycle drives alu_b_sel_o=11 (shifted sign-extended immediate) and alu_a_sel_o=0 (PC). This is the same for every opcode. The opcode op_i chooses the next cycle: 0x23 load, 0x2B store, 0x00 register-register, 0x04 branch, 0x02 jump, 0x0F load-upper-immediate. Any other value traps.
- R4: A load takes 5 cycles. After decode come the address cycle (alu_a_sel_o=1, alu_b_sel_o=10, add), the read cycle (addr_sel_o=1, mem_rd_o=1) and the write-back cycle (reg_wr_o=1, wb_from_mem_o=1, dst_rd_o=0).
- R5: A store takes 4 cycles. After the address cycle comes one cycle with addr_sel_o=1 and mem_wr_o=1. In that cycle mem_rd_o=0 and reg_wr_o=0.
- R6: A register-register instruction takes 4 cycles. After decode come an execute cycle (alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=10 function-field) and a completion cycle (reg_wr_o=1, dst_rd_o=1, wb_from_mem_o=0).
- R7: A branch takes 3 cycles. Its last cycle drives alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=01 (subtract), pc_wr_cond_o=1 and pc_src_o=01 (target register). pc_wr_cond_o is never high in any other cycle.
- R8: A jump takes 3 cycles. Its last cycle drives pc_wr_o=1 and pc_src_o=10 (jump target).
- R9: A load-upper-immediate takes 4 cycles. After decode come a shift cycle (alu_b_sel_o=10, alu_op_o=11 meaning shift B left by 16) and a write-back cycle (reg_wr_o=1, dst_rd_o=0, wb_from_mem_o=0).
- R10: An undefined opcode leads, after decode, to one trap cycle and then fetch. The trap cycle drives cause_wr_o=1, epc_wr_o=1, cause_code_o=0, pc_wr_o=1, pc_src_o=11 (handler address 0x80000180), alu_a_sel_o=0, alu_b_sel_o=01 and alu_op_o=01, so the ALU forms PC-4 for the EPC register.
- R11: If ovf_i is high in a register-register completion cycle, reg_wr_o is 0 in that cycle. The next cycle is a trap cycle, as in R10, but with cause_code_o=1. ovf_i has no effect in any other cycle.
- R12: Every output not named for a cycle in R2 to R11 is 0 in that cycle. mem_rd_o and mem_wr_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Opcode field of the instruction register |
| ovf_i | input | 1 | ALU overflow flag |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write if the ALU result is zero |
| addr_sel_o | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_wr_o | output | 1 | Instruction register load |
| wb_from_mem_o | output | 1 | Register write data from memory data register (1) or ALU output register (0) |
| dst_rd_o | output | 1 | Destination register from rd field (1) or rt field (0) |
| reg_wr_o | output | 1 | Register file write |
| alu_a_sel_o | output | 1 | ALU A from register A (1) or PC (0) |
| alu_b_sel_o | output | 2 | ALU B: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 function field, 11 shift B left 16 |
| pc_src_o | output | 2 | 00 ALU, 01 ALU output register, 10 jump target, 11 handler address |
| cause_wr_o | output | 1 | Cause register load |
| cause_code_o | output | 1 | Reason code: 0 undefined opcode, 1 overflow |
| epc_wr_o | output | 1 | EPC register load |

## Verification
The bound checker tests, on every cycle, the properties that depend only on the ports. Memory read and write never overlap. A store cycle never writes the register file or reads memory. A decode pattern always follows a fetch. The conditional PC write appears only with subtract. A load read is followed by its write-back, and a shift is followed by its write-back. A trap is always followed by fetch, and an overflowed completion always leads to a trap with cause 1. The bench is the only place that checks the full per-opcode cycle counts and the exact value of every line in every cycle. It also checks the reset state, the choice of cause code for an undefined opcode, and that ovf_i has no effect outside the completion cycle. For this it runs a mixed program against a reference model built from queues.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MRD    = 4'd3,
    ST_MWB    = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BEQ    = 4'd8,
    ST_JMP    = 4'd9,
    ST_LUSH   = 4'd10,
    ST_LUWB   = 4'd11,
    ST_TRAP   = 4'd12
  } state_t;

  typedef enum logic [2:0] {
    CL_LOAD, CL_STORE, CL_ALU, CL_BR, CL_JMP, CL_LUI, CL_BAD
  } iclass_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_from_mem;
    logic       dst_rd;
    logic       reg_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
    logic       cause_wr;
    logic       cause_code;
    logic       epc_wr;
  } ctrl_t;

  localparam logic [1:0] BSEL_REG  = 2'b00;
  localparam logic [1:0] BSEL_FOUR = 2'b01;
  localparam logic [1:0] BSEL_IMM  = 2'b10;
  localparam logic [1:0] BSEL_IMM2 = 2'b11;
  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNC  = 2'b10;
  localparam logic [1:0] AOP_SH16  = 2'b11;
  localparam logic [1:0] PSRC_ALU  = 2'b00;
  localparam logic [1:0] PSRC_OUT  = 2'b01;
  localparam logic [1:0] PSRC_JMP  = 2'b10;
  localparam logic [1:0] PSRC_TRAP = 2'b11;

endpackage

// File: rtl/mcf_opdec.sv
module mcf_opdec
  import mcf_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OPC_LW  = 6'h23,
  parameter logic [OP_W-1:0] OPC_SW  = 6'h2B,
  parameter logic [OP_W-1:0] OPC_R   = 6'h00,
  parameter logic [OP_W-1:0] OPC_BEQ = 6'h04,
  parameter logic [OP_W-1:0] OPC_J   = 6'h02,
  parameter logic [OP_W-1:0] OPC_LUI = 6'h0F
) (
  input  logic [OP_W-1:0] op_i,
  output iclass_t         cls_o
);
  always_comb begin
    if      (op_i == OPC_LW)  cls_o = CL_LOAD;
    else if (op_i == OPC_SW)  cls_o = CL_STORE;
    else if (op_i == OPC_R)   cls_o = CL_ALU;
    else if (op_i == OPC_BEQ) cls_o = CL_BR;
    else if (op_i == OPC_J)   cls_o = CL_JMP;
    else if (op_i == OPC_LUI) cls_o = CL_LUI;
    else                      cls_o = CL_BAD;
  end
endmodule

// File: rtl/mcf_next.sv
module mcf_next
  import mcf_pkg::*;
(
  input  state_t  cur_i,
  input  iclass_t cls_i,
  input  logic    ovf_i,
  output state_t  nxt_o
);
  always_comb begin
    nxt_o = ST_FETCH;
    unique case (cur_i)
      ST_FETCH:  nxt_o = ST_DECODE;
      ST_DECODE: begin
        unique case (cls_i)
          CL_LOAD, CL_STORE: nxt_o = ST_MADDR;
          CL_ALU:            nxt_o = ST_EXEC;
          CL_BR:             nxt_o = ST_BEQ;
          CL_JMP:            nxt_o = ST_JMP;
          CL_LUI:            nxt_o = ST_LUSH;
          default:           nxt_o = ST_TRAP;
        endcase
      end
      ST_MADDR:  nxt_o = (cls_i == CL_LOAD) ? ST_MRD : ST_MWR;
      ST_MRD:    nxt_o = ST_MWB;
      ST_EXEC:   nxt_o = ST_RWB;
      ST_RWB:    nxt_o = ovf_i ? ST_TRAP : ST_FETCH;
      ST_LUSH:   nxt_o = ST_LUWB;
      default:   nxt_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcf_outdec.sv
module mcf_outdec
  import mcf_pkg::*;
(
  input  state_t cur_i,
  input  logic   ovf_i,
  input  logic   reason_i,
  output ctrl_t  c_o
);
  always_comb begin
    c_o = '0;
    unique case (cur_i)
      ST_FETCH: begin
        c_o.mem_rd    = 1'b1;
        c_o.ir_wr     = 1'b1;
        c_o.pc_wr     = 1'b1;
        c_o.alu_b_sel = BSEL_FOUR;
      end
      ST_DECODE: c_o.alu_b_sel = BSEL_IMM2;
      ST_MADDR: begin
        c_o.alu_a_sel = 1'b1;
        c_o.alu_b_sel = BSEL_IMM;
      end
      ST_MRD: begin
        c_o.addr_sel = 1'b1;
        c_o.mem_rd   = 1'b1;
      end
      ST_MWB: begin
        c_o.reg_wr      = 1'b1;
        c_o.wb_from_mem = 1'b1;
      end
      ST_MWR: begin
        c_o.addr_sel = 1'b1;
        c_o.mem_wr   = 1'b1;
      end
      ST_EXEC: begin
        c_o.alu_a_sel = 1'b1;
        c_o.alu_op    = AOP_FUNC;
      end
      ST_RWB: begin
        c_o.dst_rd = 1'b1;
        c_o.reg_wr = ~ovf_i;
      end
      ST_BEQ: begin
        c_o.alu_a_sel  = 1'b1;
        c_o.alu_op     = AOP_SUB;
        c_o.pc_wr_cond = 1'b1;
        c_o.pc_src     = PSRC_OUT;
      end
      ST_JMP: begin
        c_o.pc_wr  = 1'b1;
        c_o.pc_src = PSRC_JMP;
      end
      ST_LUSH: begin
        c_o.alu_b_sel = BSEL_IMM;
        c_o.alu_op    = AOP_SH16;
      end
      ST_LUWB: c_o.reg_wr = 1'b1;
      ST_TRAP: begin
        c_o.cause_wr   = 1'b1;
        c_o.epc_wr     = 1'b1;
        c_o.cause_code = reason_i;
        c_o.pc_wr      = 1'b1;
        c_o.pc_src     = PSRC_TRAP;
        c_o.alu_b_sel  = BSEL_FOUR;
        c_o.alu_op     = AOP_SUB;
      end
      default: c_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcf_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OPC_LW  = 6'h23,
  parameter logic [OP_W-1:0] OPC_SW  = 6'h2B,
  parameter logic [OP_W-1:0] OPC_R   = 6'h00,
  parameter logic [OP_W-1:0] OPC_BEQ = 6'h04,
  parameter logic [OP_W-1:0] OPC_J   = 6'h02,
  parameter logic [OP_W-1:0] OPC_LUI = 6'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic            ovf_i,
  output logic            pc_wr_o,
  output logic            pc_wr_cond_o,
  output logic            addr_sel_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            ir_wr_o,
  output logic            wb_from_mem_o,
  output logic            dst_rd_o,
  output logic            reg_wr_o,
  output logic            alu_a_sel_o,
  output logic [1:0]      alu_b_sel_o,
  output logic [1:0]      alu_op_o,
  output logic [1:0]      pc_src_o,
  output logic            cause_wr_o,
  output logic            cause_code_o,
  output logic            epc_wr_o
);
  localparam logic REASON_BADOP = 1'b0;
  localparam logic REASON_OVF   = 1'b1;

  state_t  cur_q, nxt;
  iclass_t cls;
  logic    reason_q;
  ctrl_t   raw, ctl;

  mcf_opdec #(
    .OP_W(OP_W), .OPC_LW(OPC_LW), .OPC_SW(OPC_SW), .OPC_R(OPC_R),
    .OPC_BEQ(OPC_BEQ), .OPC_J(OPC_J), .OPC_LUI(OPC_LUI)
  ) u_dec (
    .op_i (op_i),
    .cls_o(cls)
  );

  mcf_next u_next (
    .cur_i(cur_q),
    .cls_i(cls),
    .ovf_i(ovf_i),
    .nxt_o(nxt)
  );

  mcf_outdec u_out (
    .cur_i   (cur_q),
    .ovf_i   (ovf_i),
    .reason_i(reason_q),
    .c_o     (raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= ST_FETCH;
      reason_q <= REASON_BADOP;
    end else begin
      cur_q <= nxt;
      if (nxt == ST_TRAP)
        reason_q <= (cur_q == ST_RWB) ? REASON_OVF : REASON_BADOP;
    end
  end

  always_comb ctl = rst_n ? raw : '0;

  assign pc_wr_o       = ctl.pc_wr;
  assign pc_wr_cond_o  = ctl.pc_wr_cond;
  assign addr_sel_o    = ctl.addr_sel;
  assign mem_rd_o      = ctl.mem_rd;
  assign mem_wr_o      = ctl.mem_wr;
  assign ir_wr_o       = ctl.ir_wr;
  assign wb_from_mem_o = ctl.wb_from_mem;
  assign dst_rd_o      = ctl.dst_rd;
  assign reg_wr_o      = ctl.reg_wr;
  assign alu_a_sel_o   = ctl.alu_a_sel;
  assign alu_b_sel_o   = ctl.alu_b_sel;
  assign alu_op_o      = ctl.alu_op;
  assign pc_src_o      = ctl.pc_src;
  assign cause_wr_o    = ctl.cause_wr;
  assign cause_code_o  = ctl.cause_code;
  assign epc_wr_o      = ctl.epc_wr;
endmodule

// File: rtl/mcf_checker.sv
module mcf_checker #(
  parameter int OP_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op_i,
  input logic            ovf_i,
  input logic            pc_wr_o,
  input logic            pc_wr_cond_o,
  input logic            addr_sel_o,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            ir_wr_o,
  input logic            wb_from_mem_o,
  input logic            dst_rd_o,
  input logic            reg_wr_o,
  input logic            alu_a_sel_o,
  input logic [1:0]      alu_b_sel_o,
  input logic [1:0]      alu_op_o,
  input logic [1:0]      pc_src_o,
  input logic            cause_wr_o,
  input logic            cause_code_o,
  input logic            epc_wr_o
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !(pc_wr_o || pc_wr_cond_o || mem_rd_o || mem_wr_o || ir_wr_o ||
                 reg_wr_o || cause_wr_o || epc_wr_o));

  a_r12_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  a_r5_store_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (!reg_wr_o && !mem_rd_o && addr_sel_o));

  a_r2_decode_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr_o |=> (alu_b_sel_o == 2'b11 && !ir_wr_o && !pc_wr_o));

  a_r7_cond_with_sub: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond_o |-> (alu_op_o == 2'b01 && pc_src_o == 2'b01));

  a_r4_read_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && addr_sel_o) |=> (reg_wr_o && wb_from_mem_o));

  a_r9_shift_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op_o == 2'b11) |=> (reg_wr_o && !wb_from_mem_o && !dst_rd_o));

  a_r10_trap_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr_o |=> ir_wr_o);

  a_r11_ovf_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_rd_o && ovf_i) |-> (!reg_wr_o ##1 (cause_wr_o && cause_code_o && epc_wr_o)));
endmodule

bind mc_ctrl_fsm mcf_checker #(.OP_W(OP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .ovf_i(ovf_i),
  .pc_wr_o(pc_wr_o), .pc_wr_cond_o(pc_wr_cond_o), .addr_sel_o(addr_sel_o),
  .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .ir_wr_o(ir_wr_o),
  .wb_from_mem_o(wb_from_mem_o), .dst_rd_o(dst_rd_o), .reg_wr_o(reg_wr_o),
  .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o),
  .pc_src_o(pc_src_o), .cause_wr_o(cause_wr_o), .cause_code_o(cause_code_o),
  .epc_wr_o(epc_wr_o)
);

// File: tb/test_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module test_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] op_i = '0;
  logic       ovf_i = 1'b0;
  logic pc_wr_o, pc_wr_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, ir_wr_o;
  logic wb_from_mem_o, dst_rd_o, reg_wr_o, alu_a_sel_o, cause_wr_o, cause_code_o, epc_wr_o;
  logic [1:0] alu_b_sel_o, alu_op_o, pc_src_o;

  always #4 clk = ~clk;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .ovf_i(ovf_i),
    .pc_wr_o(pc_wr_o), .pc_wr_cond_o(pc_wr_cond_o), .addr_sel_o(addr_sel_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .ir_wr_o(ir_wr_o),
    .wb_from_mem_o(wb_from_mem_o), .dst_rd_o(dst_rd_o), .reg_wr_o(reg_wr_o),
    .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o),
    .pc_src_o(pc_src_o), .cause_wr_o(cause_wr_o), .cause_code_o(cause_code_o),
    .epc_wr_o(epc_wr_o)
  );

  // observed control word, bit 20 down to bit 2; bits 1:0 unused
  wire [20:0] act = {pc_wr_o, pc_wr_cond_o, addr_sel_o, mem_rd_o, mem_wr_o, ir_wr_o,
                     wb_from_mem_o, dst_rd_o, reg_wr_o, alu_a_sel_o, alu_b_sel_o,
                     alu_op_o, pc_src_o, cause_wr_o, epc_wr_o, cause_code_o, 2'b00};

  localparam logic [20:0] PW = 21'h1 << 20, PWC = 21'h1 << 19, ADR = 21'h1 << 18;
  localparam logic [20:0] MRD = 21'h1 << 17, MWR = 21'h1 << 16, IRW = 21'h1 << 15;
  localparam logic [20:0] WBM = 21'h1 << 14, DRD = 21'h1 << 13, RWR = 21'h1 << 12;
  localparam logic [20:0] ASA = 21'h1 << 11, CWR = 21'h1 << 4, EWR = 21'h1 << 3;
  localparam logic [20:0] CC = 21'h1 << 2;

  function automatic logic [20:0] bsel(input int v); return 21'(v) << 9; endfunction
  function automatic logic [20:0] aop(input int v);  return 21'(v) << 7; endfunction
  function automatic logic [20:0] psrc(input int v); return 21'(v) << 5; endfunction

  int checks = 0, errors = 0;
  bit done = 0;
  logic [20:0] expq[$];
  string       tagq[$];

  task automatic chk(input logic [20:0] a, input logic [20:0] e, input string tag);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic push(input logic [20:0] v, input string tag);
    expq.push_back(v);
    tagq.push_back(tag);
  endtask

  task automatic trap(input bit ovf_cause, input string tag);
    push(CWR | EWR | (ovf_cause ? CC : 21'h0) | PW | psrc(3) | bsel(1) | aop(1), tag);
  endtask

  // loads the expected cycle sequence of one instruction and drives its inputs
  task automatic load_instr(input logic [5:0] op, input bit ov);
    op_i  = op;
    ovf_i = ov;
    push(PW | MRD | IRW | bsel(1), "R2 fetch");
    push(bsel(3), "R3 decode");
    case (op)
      6'h23: begin
        push(ASA | bsel(2), "R4 address");
        push(ADR | MRD, "R4 read");
        push(RWR | WBM, "R4 writeback");
      end
      6'h2B: begin
        push(ASA | bsel(2), "R5 address");
        push(ADR | MWR, "R5 store");
      end
      6'h00: begin
        push(ASA | aop(2), "R6 execute");
        if (ov) begin
          push(DRD, "R11 suppressed write");
          trap(1'b1, "R11 overflow trap");
        end else push(DRD | RWR, "R6 complete");
      end
      6'h04: push(ASA | aop(1) | PWC | psrc(1), "R7 branch");
      6'h02: push(PW | psrc(2), "R8 jump");
      6'h0F: begin
        push(bsel(2) | aop(3), "R9 shift");
        push(RWR, "R9 writeback");
      end
      default: trap(1'b0, "R10 undefined opcode trap");
    endcase
  endtask

  localparam int N = 14;
  logic [5:0] prog_op [N] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02, 6'h0F, 6'h3F,
                              6'h00, 6'h23, 6'h0F, 6'h01, 6'h00, 6'h2B, 6'h04};
  // ovf high on non-arithmetic entries exercises R11 "no effect elsewhere"
  bit prog_ov [N] = '{0, 1, 0, 1, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0};

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(act, 21'h0, "R1 outputs quiet in reset");
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < N || expq.size() > 0; ) begin
      @(negedge clk);
      if (expq.size() == 0) begin
        load_instr(prog_op[i], prog_ov[i]);
        i++;
      end
      chk(act, expq.pop_front(), tagq.pop_front());
    end
    // after the last instruction a new fetch must start (R12 mem excl seen throughout)
    op_i = 6'h02;
    @(negedge clk);
    chk(act, PW | MRD | IRW | bsel(1), "R2 fetch after program");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule